// File: doc/BRIEF.md
# Phase-Selected Azimuth Accumulator Cell

This block is one cell of a linear chain of identical cells that together form an image from a stream of complex radar samples. Each cell owns one phase `PHASE` out of a frame of `2*HALF_SPAN+1` image columns. It produces every image column whose index is congruent to that phase. The partial sums stay inside the cell. The weighting coefficients travel past the partial sums through a shift register, and that register links into the registers of the neighbouring cells to make one long ring.

Each time the sample strobe is asserted, the cell reads the coefficient at the tail of its coefficient register. It multiplies that coefficient by the complex sample that is broadcast to all cells. It adds the product to the partial sum for the same row, which it takes from a `ROWS`-deep recirculating accumulator line. During its own column it sends the saturated sum to the shared image bus with an enable flag, and it writes zero back into the accumulator line. This makes every finished column the sum of exactly one frame of columns.

A row counter and a column counter follow the sample stream. A frame-sync flag that comes with a strobe marks that sample as row 0 of column 0.

Top module: `sar_phase_cell`

## Requirements
- R1: While reset is asserted, `img_oe_o` is 0, both image words are 0, and both coefficient outputs are 0.
- R2: For each strobed sample, the product is re = dr*cr − di*ci and im = dr*ci + di*cr. All operands are two's-complement, and c is the coefficient present on `cof_re_o`/`cof_im_o` before that strobe's clock edge.
- R3: The sum formed for a sample is the product plus the value the accumulator line held for the same row. That value was written `ROWS` strobes earlier.
- R4: A sample in column `PHASE` writes zero into the accumulator line. A sample in any other column writes its sum.
- R5: `img_oe_o` is 1 in the cycle after a strobe whose column equals `PHASE` and 0 in every other cycle. While it is 0, both image words are 0.
- R6: When the output is enabled, each image word is the sum clamped to the signed range of `OW` bits.
- R7: `cof_re_o`/`cof_im_o` show the coefficient that entered on `cof_re_i`/`cof_im_i` `ROWS` strobes earlier. The coefficient outputs are 0 until that many strobes have occurred.
- R8: The row advances by one on each strobe and wraps from `ROWS-1` to 0. At each wrap the column advances modulo `2*HALF_SPAN+1`. A strobe with `frm_sync_i` high is treated as row 0 of column 0.
- R9: A cycle without a strobe changes no counter, coefficient or accumulator state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en_i | input | 1 | Sample strobe; one sample is consumed per asserted cycle |
| frm_sync_i | input | 1 | With a strobe, marks the sample as row 0 of column 0 |
| dat_re_i | input | DW | Broadcast sample, real part (signed) |
| dat_im_i | input | DW | Broadcast sample, imaginary part (signed) |
| cof_re_i | input | DW | Coefficient ring input, real |
| cof_im_i | input | DW | Coefficient ring input, imaginary |
| cof_re_o | output | DW | Coefficient ring output, real |
| cof_im_o | output | DW | Coefficient ring output, imaginary |
| img_oe_o | output | 1 | Shared-bus drive enable |
| img_re_o | output | OW | Image word, real (0 when not enabled) |
| img_im_o | output | OW | Image word, imaginary (0 when not enabled) |

## Verification
The image outputs and the enable change exactly one clock after the strobe that produces them, so the checks compare them one cycle after each strobe. The coefficient outputs come straight from the tail register of the coefficient line and change in the same edge that consumes a strobe. A behavioural model in the bench is advanced once for each clock, using the inputs the bench has just driven, and the outputs are sampled on the falling edge after the next rising edge. The stimulus uses small operands to keep sums exact, full-range operands to force clamping, strobes with gaps between them, and frame resyncs in the middle of a frame.

// File: rtl/sar_cell_pkg.sv
package sar_cell_pkg;
  // width of one complex product component for DW-bit operands
  function automatic int prod_width(input int dw);
    return 2 * dw + 1;
  endfunction

  // accumulator width: product plus growth over a full frame, plus guard bit
  function automatic int acc_width(input int dw, input int frame);
    return 2 * dw + 1 + $clog2(frame) + 1;
  endfunction
endpackage

// File: rtl/sar_cell_seq.sv
module sar_cell_seq #(
  parameter int ROWS  = 8,
  parameter int FRAME = 5,
  parameter int PHASE = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en_i,
  input  logic frm_sync_i,
  output logic in_phase_o
);
  localparam int RW = (ROWS  > 1) ? $clog2(ROWS)  : 1;
  localparam int CW = (FRAME > 1) ? $clog2(FRAME) : 1;

  logic [RW-1:0] row_q, row_d, row_cur;
  logic [CW-1:0] col_q, col_d, col_cur;

  always_comb begin
    row_cur = frm_sync_i ? '0 : row_q;
    col_cur = frm_sync_i ? '0 : col_q;
    row_d   = row_q;
    col_d   = col_q;
    if (smp_en_i) begin
      if (row_cur == RW'(ROWS - 1)) begin
        row_d = '0;
        col_d = (col_cur == CW'(FRAME - 1)) ? '0 : col_cur + 1'b1;
      end else begin
        row_d = row_cur + 1'b1;
        col_d = col_cur;
      end
    end
  end

  assign in_phase_o = (col_cur == CW'(PHASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  // R8
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en_i && frm_sync_i) |=> (row_q == RW'(1) && col_q == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en_i |=> ($stable(row_q) && $stable(col_q)));
endmodule

// File: rtl/sar_cplx_mac.sv
module sar_cplx_mac #(
  parameter int DW = 4,
  parameter int PW = 9
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic signed [PW-1:0] p_re,
  output logic signed [PW-1:0] p_im
);
  logic signed [PW-1:0] ar, ai, br, bi;

  always_comb begin
    ar   = $signed({{(PW-DW){a_re[DW-1]}}, a_re});
    ai   = $signed({{(PW-DW){a_im[DW-1]}}, a_im});
    br   = $signed({{(PW-DW){b_re[DW-1]}}, b_re});
    bi   = $signed({{(PW-DW){b_im[DW-1]}}, b_im});
    p_re = ar * br - ai * bi;
    p_im = ar * bi + ai * br;
  end
endmodule

// File: rtl/sar_delay_line.sv
module sar_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else if (en_i) begin
      st[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[DEPTH-1];

  // R9
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/sar_phase_cell.sv
module sar_phase_cell
  import sar_cell_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int HALF_SPAN = 2,
  parameter int PHASE     = 0,
  parameter int DW        = 4,
  parameter int OW        = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en_i,
  input  logic                 frm_sync_i,
  input  logic signed [DW-1:0] dat_re_i,
  input  logic signed [DW-1:0] dat_im_i,
  input  logic signed [DW-1:0] cof_re_i,
  input  logic signed [DW-1:0] cof_im_i,
  output logic signed [DW-1:0] cof_re_o,
  output logic signed [DW-1:0] cof_im_o,
  output logic                 img_oe_o,
  output logic signed [OW-1:0] img_re_o,
  output logic signed [OW-1:0] img_im_o
);
  localparam int FRAME = 2 * HALF_SPAN + 1;
  localparam int PW    = prod_width(DW);
  localparam int AW    = acc_width(DW, FRAME);

  logic                 in_phase;
  logic [2*DW-1:0]      cof_tail;
  logic signed [PW-1:0] p_re, p_im;
  logic [2*AW-1:0]      acc_tail, acc_wr;
  logic signed [AW-1:0] sum_re, sum_im;
  logic signed [OW-1:0] sat_re, sat_im;
  logic                 oe_d;
  logic signed [OW-1:0] re_d, im_d;

  sar_cell_seq #(.ROWS(ROWS), .FRAME(FRAME), .PHASE(PHASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en_i), .frm_sync_i(frm_sync_i),
    .in_phase_o(in_phase)
  );

  sar_delay_line #(.W(2*DW), .DEPTH(ROWS)) u_cof_line (
    .clk(clk), .rst_n(rst_n), .en_i(smp_en_i),
    .d_i({cof_re_i, cof_im_i}), .q_o(cof_tail)
  );

  assign cof_re_o = cof_tail[2*DW-1:DW];
  assign cof_im_o = cof_tail[DW-1:0];

  sar_cplx_mac #(.DW(DW), .PW(PW)) u_mac (
    .a_re(dat_re_i), .a_im(dat_im_i), .b_re(cof_re_o), .b_im(cof_im_o),
    .p_re(p_re), .p_im(p_im)
  );

  always_comb begin
    sum_re = $signed(acc_tail[2*AW-1:AW]) + $signed({{(AW-PW){p_re[PW-1]}}, p_re});
    sum_im = $signed(acc_tail[AW-1:0])    + $signed({{(AW-PW){p_im[PW-1]}}, p_im});
    acc_wr = in_phase ? '0 : {sum_re, sum_im};
  end

  sar_delay_line #(.W(2*AW), .DEPTH(ROWS)) u_acc_line (
    .clk(clk), .rst_n(rst_n), .en_i(smp_en_i),
    .d_i(acc_wr), .q_o(acc_tail)
  );

  generate
    if (OW >= AW) begin : g_wide
      assign sat_re = OW'(sum_re);
      assign sat_im = OW'(sum_im);
    end else begin : g_clamp
      localparam logic signed [AW-1:0] HI = AW'((1 << (OW-1)) - 1);
      localparam logic signed [AW-1:0] LO = -AW'(1 << (OW-1));
      always_comb begin
        if (sum_re > HI)      sat_re = OW'(HI);
        else if (sum_re < LO) sat_re = OW'(LO);
        else                  sat_re = OW'(sum_re);
        if (sum_im > HI)      sat_im = OW'(HI);
        else if (sum_im < LO) sat_im = OW'(LO);
        else                  sat_im = OW'(sum_im);
      end
    end
  endgenerate

  always_comb begin
    oe_d = smp_en_i && in_phase;
    re_d = oe_d ? sat_re : '0;
    im_d = oe_d ? sat_im : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_oe_o <= 1'b0;
      img_re_o <= '0;
      img_im_o <= '0;
    end else begin
      img_oe_o <= oe_d;
      img_re_o <= re_d;
      img_im_o <= im_d;
    end
  end

  // R5
  oe_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_oe_o |-> $past(smp_en_i));
  // R5
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !img_oe_o |-> (img_re_o == '0 && img_im_o == '0));
  // R4
  phase_col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en_i && in_phase) |-> (acc_wr == '0));
endmodule

// File: tb/sar_phase_cell_tb.sv
`timescale 1ns/1ps
module sar_phase_cell_tb;
  localparam int ROWS = 4, HALF = 2, FRAME = 2*HALF+1, PH = 2, DW = 4, OW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_en, frm_sync;
  logic signed [DW-1:0] d_re, d_im, c_re, c_im, co_re, co_im;
  logic oe;
  logic signed [OW-1:0] i_re, i_im;

  always #2.5 clk = ~clk;

  sar_phase_cell #(.ROWS(ROWS), .HALF_SPAN(HALF), .PHASE(PH), .DW(DW), .OW(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en), .frm_sync_i(frm_sync),
    .dat_re_i(d_re), .dat_im_i(d_im), .cof_re_i(c_re), .cof_im_i(c_im),
    .cof_re_o(co_re), .cof_im_o(co_im),
    .img_oe_o(oe), .img_re_o(i_re), .img_im_o(i_im)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  int cq_re[$], cq_im[$], ln_re[$], ln_im[$];
  int row = 0, col = 0;
  int e_oe = 0, e_re = 0, e_im = 0;
  string last_tag = "R1";

  function automatic int satv(int v);
    int hi = (1 << (OW-1)) - 1;
    int lo = -(1 << (OW-1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare outputs from the last edge, then drive one cycle and advance the model
  task automatic step(bit en, bit sy, int ar, int ai, int cr, int ci, string tag);
    chk("R5", "img_oe", int'(oe), e_oe);
    chk(last_tag, "img_re", int'(i_re), e_re);
    chk(last_tag, "img_im", int'(i_im), e_im);
    chk("R7", "cof_re", int'(co_re), cq_re[0]);
    chk("R7", "cof_im", int'(co_im), cq_im[0]);
    smp_en = en; frm_sync = sy;
    d_re = DW'(ar); d_im = DW'(ai); c_re = DW'(cr); c_im = DW'(ci);
    last_tag = tag;
    if (en) begin
      int rc = sy ? 0 : row;
      int cc = sy ? 0 : col;
      int pr = ar*cq_re[0] - ai*cq_im[0];
      int pi = ar*cq_im[0] + ai*cq_re[0];
      int sr = ln_re[0] + pr;
      int si = ln_im[0] + pi;
      void'(ln_re.pop_front()); void'(ln_im.pop_front());
      ln_re.push_back(cc == PH ? 0 : sr);
      ln_im.push_back(cc == PH ? 0 : si);
      void'(cq_re.pop_front()); void'(cq_im.pop_front());
      cq_re.push_back(cr); cq_im.push_back(ci);
      e_oe = (cc == PH);
      e_re = e_oe ? satv(sr) : 0;
      e_im = e_oe ? satv(si) : 0;
      if (rc == ROWS-1) begin
        row = 0; col = (cc == FRAME-1) ? 0 : cc + 1;
      end else begin
        row = rc + 1; col = cc;
      end
    end else begin
      e_oe = 0; e_re = 0; e_im = 0;
    end
    @(negedge clk);
  endtask

  function automatic int rs(int lo, int hi);
    return int'($urandom_range(hi - lo)) + lo;
  endfunction

  initial begin
    for (int i = 0; i < ROWS; i++) begin
      cq_re.push_back(0); cq_im.push_back(0); ln_re.push_back(0); ln_im.push_back(0);
    end
    rst_n = 0; smp_en = 0; frm_sync = 0; d_re = 0; d_im = 0; c_re = 0; c_im = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset oe", int'(oe), 0);
    chk("R1", "reset img_re", int'(i_re), 0);
    chk("R1", "reset cof_re", int'(co_re), 0);
    chk("R1", "reset cof_im", int'(co_im), 0);
    rst_n = 1;
    @(negedge clk);
    // R2 R3 R4: small operands, exact sums across three frames
    for (int n = 0; n < 3*FRAME*ROWS; n++)
      step(1, n == 0, rs(-1,1), rs(-1,1), rs(-2,2), rs(-2,2), "R2 R3 R4");
    // R6: full-range operands force clamping
    for (int n = 0; n < 4*FRAME*ROWS; n++)
      step(1, 0, rs(-8,7), rs(-8,7), (n % 3 == 0) ? -8 : 7, (n % 2) ? -8 : 7, "R6");
    // R9: strobes with gaps, no state change in idle cycles
    for (int n = 0; n < 3*FRAME*ROWS; n++)
      step($urandom_range(2) != 0, 0, rs(-3,3), rs(-3,3), rs(-4,4), rs(-4,4), "R9");
    // R8: resync in the middle of a frame
    for (int n = 0; n < 3*FRAME*ROWS; n++)
      step(1, (n == 7) || (n == 33), rs(-2,2), rs(-2,2), rs(-3,3), rs(-3,3), "R8");
    // drain: strobes with zero data flush a final column
    for (int n = 0; n < 2*FRAME*ROWS; n++)
      step(1, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R5");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule